// File: doc/BRIEF.md
# Synchronous Up-Counter from JK Stages with Gated Reset

This block is an N-bit binary up-counter assembled from JK flip-flop stages that all share one clock. Every rising clock edge is a count event: with the reset input low the value advances by one and wraps past all ones back to zero. A carry chain ANDs together the lower count bits to form each stage's toggle condition. That condition feeds both the J and K inputs of the stage, so a stage toggles exactly when every bit below it is one.

Clearing is synchronous and passes only through the excitation logic. The flip-flops have no clear pin. While reset is high, every stage receives J=0 and K=1, which clears it on the next edge. The lowest stage is wired differently from the others: its K input is tied high and its J input is the inverse of reset. It therefore toggles on every ordinary edge and clears on a reset edge. The value at power-up is undefined until the first edge at which reset is high.

Top module: `jk_sync_counter`

## Requirements
- R1: At each rising edge of `clk` with `rst` low, `count` becomes (previous `count` + 1) modulo 2^WIDTH.
- R2: When `count` is all ones and `rst` is low at a rising edge, `count` becomes zero.
- R3: When `rst` is high at a rising edge, `count` becomes zero, whatever its prior value.
- R4: `rst` acts only at rising edges. Raising or lowering it between edges leaves `count` unchanged until the next edge.
- R5: While `rst` stays high across several consecutive edges, `count` remains zero after each of them.
- R6: The first edge after `rst` is released moves `count` from zero to one.
- R7: Bit 0 of `count` inverts at every rising edge at which `rst` is low.
- R8: For bit i > 0, the bit inverts at a non-reset edge if and only if all bits below it were one before that edge.
- R9: Each stage obeys JK rules at the edge: J=0,K=1 gives 0; J=1,K=0 gives 1; J=0,K=0 keeps the value; J=1,K=1 inverts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is a count event |
| rst | input | 1 | Synchronous active-high clear, applied through J/K gating |
| count | output | WIDTH | Current counter value, bit 0 least significant |

## Verification
The assertions assume that `rst` has been high at at least one edge before any count relation is judged, because the stage values are undefined until then. An internal armed flag blocks the step, wrap and per-bit properties until that first reset edge has occurred. The assertions also assume that `rst` is stable around each rising edge. The stimulus always raises reset before the first edge and changes `rst` only near falling edges or in mid-phase pulses that end before the next rising edge. It samples `count` at falling edges, half a period after the edge that updated it.

// File: rtl/jkc_pkg.sv
package jkc_pkg;

    typedef enum logic [1:0] {
        JK_HOLD   = 2'b00,
        JK_CLEAR  = 2'b01,
        JK_SET    = 2'b10,
        JK_TOGGLE = 2'b11
    } jk_act_e;

    typedef struct packed {
        logic j;
        logic k;
    } jk_pin_t;

    function automatic jk_act_e jk_decode(jk_pin_t p);
        return jk_act_e'({p.j, p.k});
    endfunction

    function automatic logic jk_next(logic q, jk_pin_t p);
        logic nq;
        case (jk_decode(p))
            JK_HOLD:   nq = q;
            JK_CLEAR:  nq = 1'b0;
            JK_SET:    nq = 1'b1;
            default:   nq = ~q;
        endcase
        return nq;
    endfunction

endpackage

// File: rtl/jk_flop.sv
module jk_flop
    import jkc_pkg::*;
(
    input  logic    clk,
    input  jk_pin_t drv,
    output logic    q
);

    always_ff @(posedge clk) begin
        q <= jk_next(q, drv);
    end

    // R9: JK behaviour at the edge
    p_jk_clear_r9: assert property (@(posedge clk)
        (!drv.j && drv.k) |=> !q);
    p_jk_set_r9: assert property (@(posedge clk)
        (drv.j && !drv.k) |=> q);
    p_jk_hold_r9: assert property (@(posedge clk)
        (!drv.j && !drv.k) |=> $stable(q));

endmodule

// File: rtl/carry_chain.sv
module carry_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    output logic [WIDTH-1:0] tgl
);

    always_comb begin
        logic acc;
        acc = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            tgl[i] = acc;
            acc    = acc & cnt[i];
        end
    end

endmodule

// File: rtl/reset_gate.sv
module reset_gate
    import jkc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic                  rst,
    input  logic [WIDTH-1:0]      tgl,
    output jk_pin_t [WIDTH-1:0]   exc
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_lsb
            assign exc[i].j = ~rst;
            assign exc[i].k = 1'b1;
        end else begin : g_upper
            assign exc[i].j = tgl[i] & ~rst;
            assign exc[i].k = tgl[i] | rst;
        end
    end

endmodule

// File: rtl/jk_sync_counter.sv
module jk_sync_counter
    import jkc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0]    tgl;
    jk_pin_t [WIDTH-1:0] exc;

    carry_chain #(.WIDTH(WIDTH)) u_chain (
        .cnt (count),
        .tgl (tgl)
    );

    reset_gate #(.WIDTH(WIDTH)) u_gate (
        .rst (rst),
        .tgl (tgl),
        .exc (exc)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        jk_flop u_stage (
            .clk (clk),
            .drv (exc[i]),
            .q   (count[i])
        );
    end

    // Set once a reset edge has defined the stage values
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        armed |=> count == WIDTH'($past(count) + 1'b1));
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && count == ALL_ONES) |=> count == '0);
    p_reset_clear_r3: assert property (@(posedge clk)
        rst |=> count == '0);
    p_lsb_flip_r7: assert property (@(posedge clk) disable iff (rst)
        armed |=> count[0] != $past(count[0]));

    for (genvar b = 1; b < WIDTH; b++) begin : g_chk
        p_upper_flip_r8: assert property (@(posedge clk) disable iff (rst)
            armed |=> (count[b] != $past(count[b])) == (&$past(count[b-1:0])));
    end

endmodule

// File: tb/jk_sync_counter_tb.sv
module jk_sync_counter_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] count;

    int n_checks = 0;
    int n_fails  = 0;

    jk_sync_counter #(.WIDTH(W)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct packed {
        logic         r;
        logic [W-1:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0},  '{1'b0, 4'd1},  '{1'b0, 4'd2},  '{1'b0, 4'd3},
        '{1'b1, 4'd0},  '{1'b0, 4'd1},  '{1'b0, 4'd2},  '{1'b0, 4'd3},
        '{1'b0, 4'd4},  '{1'b0, 4'd5},  '{1'b0, 4'd6},  '{1'b0, 4'd7},
        '{1'b0, 4'd8},  '{1'b0, 4'd9},  '{1'b0, 4'd10}, '{1'b0, 4'd11},
        '{1'b0, 4'd12}, '{1'b0, 4'd13}, '{1'b0, 4'd14}, '{1'b0, 4'd15},
        '{1'b0, 4'd0},  '{1'b0, 4'd1},  '{1'b1, 4'd0}
    };

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r);
        rst = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    logic [W-1:0] ref_cnt;

    initial begin : watchdog
        #2000000;
        n_fails++;
        $display("FAIL watchdog: count=%0d expected=finish", count);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        // Table walk: R1 step, R2 wrap, R3 reset mid-count
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].r);
            check(VECS[i].r ? "R3" : (VECS[i].exp == 0 ? "R2" : "R1"),
                  count, VECS[i].exp);
        end
        ref_cnt = '0;

        // R6: release after reset gives one
        step(1'b0); ref_cnt = 1;
        check("R6", count, ref_cnt);

        // R7/R8 against reference over a full wrap
        for (int i = 0; i < 18; i++) begin
            logic [W-1:0] prev;
            prev = count;
            step(1'b0);
            ref_cnt = ref_cnt + 1'b1;
            check("R8", count, ref_cnt);
            check("R7", count[0] ^ prev[0], 1'b1);
        end

        // R4: reset pulse between edges has no effect
        begin
            logic [W-1:0] hold;
            hold = count;
            #3 rst = 1'b1;
            #3 rst = 1'b0;
            check("R4", count, hold);
            @(posedge clk);
            #2 rst = 1'b1;
            #4 rst = 1'b0;
            check("R4", count, hold + 1'b1);
            @(negedge clk);
            check("R4", count, hold + 1'b1);
            ref_cnt = hold + 1'b1;
        end

        // R5: reset held for several edges
        for (int i = 0; i < 5; i++) begin
            step(1'b1);
            check("R5", count, '0);
        end
        step(1'b0);
        check("R6", count, 4'd1);

        // R3: reset from all ones
        for (int i = 0; i < 14; i++) step(1'b0);
        check("R2", count, 4'd15);
        step(1'b1);
        check("R3", count, '0);
        step(1'b0);
        check("R6", count, 4'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule